// File: doc/BRIEF.md
# Single-Write I2C Register Engine for a Power-Management Device

This block is a small I2C master dedicated to one task. It sends a single one-byte register write to a power-management device on its own two-wire bus. Software programs three fields into a command register: the 7-bit device address, the target register address and the data byte. It then sets the command's go bit. The engine runs the whole bus sequence without further help. It clears the go bit itself when the STOP condition has completed, so software polls that bit to detect completion.

A clock register sets the SCL high and low counts. Each count is shorter than the real half-period by a fixed padding: the high count by 5 system clocks and the low count by 7. Software picks the counts for roughly a 40/60 high/low duty cycle and a bus rate of no more than 400 kHz. A mode register keeps a high-speed enable bit, a master code and two further enables. These bits are only stored, because the transfer always runs in standard or fast timing.

The bus side consists of two open-drain pull-down enables and the sampled SDA level. The block has no data stream of its own. Software reaches it only through a plain register port, so there is no back-pressure: a register write is taken on the clock edge where `cfg_we` is high, and reads are combinational on `cfg_addr`.

Top module: `pwr_i2c_wr`

## Requirements
- R1: During and right after reset, both pull-down enables are low and every register (index 0 command, 1 clock, 2 mode, 3 status) reads zero.
- R2: The command register keeps the device address in bits [6:0], the register address in [15:8] and the data byte in [23:16]. Bit 24 is the go bit, and all other bits read zero.
- R3: A command write with bit 24 set while idle starts a transfer. Bit 24 reads 1 from the next cycle onward and returns to 0 in the first idle cycle after STOP.
- R4: The clock register keeps the high count H in bits [7:0] and the low count L in bits [15:8]. Every SCL high phase lasts H+5 system clocks (Th) and every SCL low phase lasts L+7 (Tl).
- R5: A transfer starts with Th cycles of both lines released, followed by Th cycles with SDA low and SCL released. Three bytes then follow MSB first: {address, 0}, the register address and the data byte. Each bit is a low phase followed by a high phase, and each byte is followed by an acknowledge bit in which SDA is released.
- R6: Within a byte, SDA takes its new value at the start of the SCL low phase and holds it steady through the following high phase.
- R7: The acknowledge level is sampled once, at cycle Th/2 (integer division, counting from 0) of the acknowledge bit's high phase. A low level means acknowledged and a high level means not acknowledged.
- R8: A not-acknowledged slot sends the engine straight into STOP after that slot's high phase, and the remaining bytes are skipped. Status bit 0 is set when that STOP ends, and bit 24 clears.
- R9: STOP is Tl cycles with SCL and SDA both low, then Th cycles with SCL released and SDA low, then Th cycles with both lines released. The engine is idle after that.
- R10: A command write while a transfer runs has no effect: the stored fields and the bus waveform stay unchanged and no second transfer starts.
- R11: The mode register keeps bits [2:0], 3, 4 and 6, and all other bits read zero. Its contents never change the transfer.
- R12: Status bit 0 is sticky. A later successful transfer leaves it set, writing 0 leaves it set, and writing 1 to bit 0 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational on cfg_addr |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| sda_drive_low | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sampled SDA bus level |

## Verification
The bench builds the block with its default parameters: 8-bit counts and pads of 5 and 7. It programs small clock counts between 0 and 6, which keeps a full three-byte transfer at a few hundred cycles. These counts still make Th odd and long enough that a device pulling SDA low only on the midpoint cycle can be told apart from one pulling it everywhere but the midpoint. The zero-count case puts the shortest half-periods (5 and 7 cycles) within reach. A behavioural model predicts the two pull-down enables and the go bit on every cycle, including early STOPs after a not-acknowledge in the first and last slots.

// File: rtl/pwi_pkg.sv
package pwi_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SSU,   // start setup: both released
    ST_SHD,   // start hold: SDA low, SCL released
    ST_BLO,   // bit, SCL low
    ST_BHI,   // bit, SCL released
    ST_PLO,   // stop lead-in: both low
    ST_PSU,   // stop setup: SDA low, SCL released
    ST_PHD    // bus free: both released
  } pwi_state_e;

  localparam logic [1:0] REG_CMD  = 2'd0;
  localparam logic [1:0] REG_CLK  = 2'd1;
  localparam logic [1:0] REG_MODE = 2'd2;
  localparam logic [1:0] REG_STAT = 2'd3;

  localparam int GO_BIT = 24;
  localparam logic [6:0] MODE_KEEP = 7'h5F;

endpackage

// File: rtl/pwi_timer.sv
module pwi_timer #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart_i,
  input  logic [TW-1:0] dur_i,
  output logic [TW-1:0] cnt_o,
  output logic          last_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_o <= '0;
    else if (restart_i) cnt_o <= '0;
    else                cnt_o <= cnt_o + 1'b1;
  end

  // >= guards against a count shrunk by software mid-phase
  assign last_o = (cnt_o >= dur_i - 1'b1);

  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !restart_i |=> cnt_o == $past(cnt_o) + 1'b1);

endmodule

// File: rtl/pwi_regs.sv
module pwi_regs
  import pwi_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic             busy_i,
  input  logic             err_set_i,
  output logic             start_o,
  output logic [6:0]       dev_o,
  output logic [7:0]       reg_o,
  output logic [7:0]       dat_o,
  output logic [CNT_W-1:0] hi_o,
  output logic [CNT_W-1:0] lo_o
);

  logic [6:0] mode_q;
  logic       err_q;
  logic       cmd_wr, clk_wr, mode_wr, stat_wr;
  logic       unused_hi;

  assign cmd_wr  = we_i && (addr_i == REG_CMD);
  assign clk_wr  = we_i && (addr_i == REG_CLK);
  assign mode_wr = we_i && (addr_i == REG_MODE);
  assign stat_wr = we_i && (addr_i == REG_STAT);
  assign start_o = cmd_wr && wdata_i[GO_BIT] && !busy_i;
  assign unused_hi = ^wdata_i[31:25];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_o  <= '0;
      reg_o  <= '0;
      dat_o  <= '0;
      hi_o   <= '0;
      lo_o   <= '0;
      mode_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (cmd_wr && !busy_i) begin
        dev_o <= wdata_i[6:0];
        reg_o <= wdata_i[15:8];
        dat_o <= wdata_i[23:16];
      end
      if (clk_wr) begin
        hi_o <= wdata_i[CNT_W-1:0];
        lo_o <= wdata_i[2*CNT_W-1:CNT_W];
      end
      if (mode_wr) mode_q <= wdata_i[6:0] & MODE_KEEP;
      if (err_set_i)                err_q <= 1'b1;
      else if (stat_wr && wdata_i[0]) err_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_CMD: begin
        rdata_o[6:0]   = dev_o;
        rdata_o[15:8]  = reg_o;
        rdata_o[23:16] = dat_o;
        rdata_o[GO_BIT] = busy_i;
      end
      REG_CLK: begin
        rdata_o[CNT_W-1:0]       = hi_o;
        rdata_o[2*CNT_W-1:CNT_W] = lo_o;
      end
      REG_MODE: rdata_o[6:0] = mode_q;
      default:  rdata_o[0]   = err_q;
    endcase
  end

  p_cmd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i && cmd_wr |=> $stable(dev_o) && $stable(reg_o) && $stable(dat_o));

  p_err_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !(stat_wr && wdata_i[0]) |=> err_q);

endmodule

// File: rtl/pwi_seq.sv
module pwi_seq
  import pwi_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int HI_PAD = 5,
  parameter int LO_PAD = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [6:0]       dev_i,
  input  logic [7:0]       reg_i,
  input  logic [7:0]       dat_i,
  input  logic [CNT_W-1:0] hi_i,
  input  logic [CNT_W-1:0] lo_i,
  input  logic             sda_i,
  output logic             busy_o,
  output logic             err_set_o,
  output logic             scl_low_o,
  output logic             sda_low_o
);

  localparam int TW = CNT_W + 4;

  pwi_state_e    state;
  logic [1:0]    byte_idx;
  logic [3:0]    bit_idx;
  logic          nack_q;
  logic [7:0]    cur_byte;
  logic [TW-1:0] th, tl, dur, cnt, mid;
  logic          last, ack_slot, sample_now;

  assign th  = TW'(hi_i) + TW'(HI_PAD);
  assign tl  = TW'(lo_i) + TW'(LO_PAD);
  assign mid = th >> 1;
  assign dur = (state == ST_BLO || state == ST_PLO) ? tl : th;

  pwi_timer #(.TW(TW)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (state == ST_IDLE || last),
    .dur_i     (dur),
    .cnt_o     (cnt),
    .last_o    (last)
  );

  assign ack_slot   = (bit_idx == 4'd8);
  assign sample_now = (state == ST_BHI) && ack_slot && (cnt == mid);

  always_comb begin
    case (byte_idx)
      2'd0:    cur_byte = {dev_i, 1'b0};
      2'd1:    cur_byte = reg_i;
      default: cur_byte = dat_i;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      byte_idx <= '0;
      bit_idx  <= '0;
      nack_q   <= 1'b0;
    end else begin
      if (sample_now && sda_i) nack_q <= 1'b1;
      case (state)
        ST_IDLE: if (start_i) begin
          state    <= ST_SSU;
          byte_idx <= '0;
          bit_idx  <= '0;
          nack_q   <= 1'b0;
        end
        ST_SSU: if (last) state <= ST_SHD;
        ST_SHD: if (last) state <= ST_BLO;
        ST_BLO: if (last) state <= ST_BHI;
        ST_BHI: if (last) begin
          if (!ack_slot) begin
            bit_idx <= bit_idx + 1'b1;
            state   <= ST_BLO;
          end else if (nack_q || byte_idx == 2'd2) begin
            state <= ST_PLO;
          end else begin
            byte_idx <= byte_idx + 1'b1;
            bit_idx  <= '0;
            state    <= ST_BLO;
          end
        end
        ST_PLO: if (last) state <= ST_PSU;
        ST_PSU: if (last) state <= ST_PHD;
        default: if (last) state <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state != ST_IDLE);
  assign err_set_o = (state == ST_PHD) && last && nack_q;
  assign scl_low_o = (state == ST_BLO) || (state == ST_PLO);

  always_comb begin
    case (state)
      ST_SHD, ST_PLO, ST_PSU: sda_low_o = 1'b1;
      ST_BLO, ST_BHI:         sda_low_o = !ack_slot && !cur_byte[3'd7 - bit_idx[2:0]];
      default:                sda_low_o = 1'b0;
    endcase
  end

  p_sda_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_BHI && cnt != '0 |-> $stable(sda_low_o));

  p_idx_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_idx <= 4'd8 && byte_idx <= 2'd2);

  p_nack_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_BHI && ack_slot && nack_q && last |=> state == ST_PLO);

endmodule

// File: rtl/pwr_i2c_wr.sv
module pwr_i2c_wr #(
  parameter int CNT_W  = 8,
  parameter int HI_PAD = 5,
  parameter int LO_PAD = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        scl_drive_low,
  output logic        sda_drive_low,
  input  logic        sda_in
);

  logic             busy, err_set, start;
  logic [6:0]       dev;
  logic [7:0]       rga, dat;
  logic [CNT_W-1:0] hi, lo;

  pwi_regs #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_i      (cfg_we),
    .addr_i    (cfg_addr),
    .wdata_i   (cfg_wdata),
    .rdata_o   (cfg_rdata),
    .busy_i    (busy),
    .err_set_i (err_set),
    .start_o   (start),
    .dev_o     (dev),
    .reg_o     (rga),
    .dat_o     (dat),
    .hi_o      (hi),
    .lo_o      (lo)
  );

  pwi_seq #(.CNT_W(CNT_W), .HI_PAD(HI_PAD), .LO_PAD(LO_PAD)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .dev_i     (dev),
    .reg_i     (rga),
    .dat_i     (dat),
    .hi_i      (hi),
    .lo_i      (lo),
    .sda_i     (sda_in),
    .busy_o    (busy),
    .err_set_o (err_set),
    .scl_low_o (scl_drive_low),
    .sda_low_o (sda_drive_low)
  );

  p_idle_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !scl_drive_low && !sda_drive_low);

endmodule

// File: tb/sim_pwr_i2c_wr.sv
module sim_pwr_i2c_wr;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        scl_drive_low, sda_drive_low, sda_in;
  logic        slave_pull = 1'b0;

  int errors = 0;
  int checks = 0;
  int hc = 0, lc = 0;
  int ack_mode [3];
  logic [2:0] q [$];
  logic [2:0] e;
  logic cur_busy = 1'b0;
  logic [31:0] v;
  bit done = 0;

  always #2 clk = ~clk;
  assign sda_in = ~(sda_drive_low | slave_pull);

  pwr_i2c_wr u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low), .sda_in(sda_in)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural expectation of one transfer: {slave_pull, scl_low, sda_low} per cycle
  task automatic build(input logic [6:0] sa, input logic [7:0] ra, input logic [7:0] dt);
    int th = hc + 5, tl = lc + 7, mid = (hc + 5) / 2;
    logic [7:0] b;
    repeat (th) q.push_back(3'b000);
    repeat (th) q.push_back(3'b001);
    for (int k = 0; k < 3; k++) begin
      b = (k == 0) ? {sa, 1'b0} : (k == 1) ? ra : dt;
      for (int i = 7; i >= 0; i--) begin
        repeat (tl) q.push_back({1'b0, 1'b1, ~b[i]});
        repeat (th) q.push_back({1'b0, 1'b0, ~b[i]});
      end
      repeat (tl) q.push_back({(ack_mode[k] == 0 || ack_mode[k] == 3), 2'b10});
      for (int j = 0; j < th; j++) begin
        logic p;
        case (ack_mode[k])
          0: p = 1'b1;
          1: p = 1'b0;
          2: p = (j == mid);
          default: p = (j != mid);
        endcase
        q.push_back({p, 2'b00});
      end
      if (ack_mode[k] == 1 || ack_mode[k] == 3) break;
    end
    repeat (tl) q.push_back(3'b011);
    repeat (th) q.push_back(3'b001);
    repeat (th) q.push_back(3'b000);
  endtask

  // Per-cycle comparison (R4 R5 R6 R9 waveform, R3 go bit)
  always @(posedge clk) begin
    #1;
    e = 3'b000;
    cur_busy = 1'b0;
    if (q.size() > 0) begin
      e = q.pop_front();
      cur_busy = 1'b1;
    end
    slave_pull = e[2];
    chk("R4 R5 R6 R9 bus waveform {scl,sda}", {30'b0, scl_drive_low, sda_drive_low}, {30'b0, e[1:0]});
    if (cfg_addr == 2'd0 && !cfg_we)
      chk("R3 go bit", {31'b0, cfg_rdata[24]}, {31'b0, cur_busy});
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    if (a == 2'd1) begin hc = d[7:0]; lc = d[15:8]; end
    if (a == 2'd0 && d[24] && !cur_busy) build(d[6:0], d[15:8], d[23:16]);
    @(negedge clk);
    cfg_we = 1'b0; cfg_addr = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
    cfg_addr = 2'd0;
  endtask

  task automatic wait_idle();
    do begin
      @(posedge clk); #2;
    end while (cur_busy || q.size() > 0);
  endtask

  task automatic acks(input int a0, input int a1, input int a2);
    ack_mode[0] = a0; ack_mode[1] = a1; ack_mode[2] = a2;
  endtask

  initial begin
    acks(0, 0, 0);
    repeat (3) @(posedge clk);
    #1 chk("R1 released in reset", {30'b0, scl_drive_low, sda_drive_low}, 32'h0);
    @(negedge clk) rst_n = 1'b1;
    for (int r = 0; r < 4; r++) begin
      rd(2'(r), v);
      chk("R1 register zero after reset", v, 32'h0);
    end

    // R2 field layout, no start
    wr(2'd0, 32'hFEFF_FFFF);
    rd(2'd0, v); chk("R2 command readback", v, 32'h00FF_FF7F);

    // R4 clock register
    wr(2'd1, 32'hFFFF_0302);
    rd(2'd1, v); chk("R4 clock readback", v, 32'h0000_0302);

    // Full transfer, all acknowledged
    wr(2'd0, 32'h01A5_3C5A);
    rd(2'd0, v); chk("R3 go set while busy", v, 32'h01A5_3C5A);
    // R10: write during transfer ignored
    wr(2'd0, 32'h0111_2233);
    rd(2'd0, v); chk("R10 fields unchanged while busy", v, 32'h01A5_3C5A);
    wait_idle();
    rd(2'd0, v); chk("R3 go cleared after stop", v, 32'h00A5_3C5A);
    rd(2'd3, v); chk("R8 no error on ack", v, 32'h0);

    // R8: NACK on register byte
    acks(0, 1, 0);
    wr(2'd0, 32'h0177_8812);
    wait_idle();
    rd(2'd3, v); chk("R8 error after nack", v, 32'h1);
    rd(2'd0, v); chk("R8 go cleared after nack", v, 32'h0077_8812);

    // R12 sticky
    acks(0, 0, 0);
    wr(2'd0, 32'h0100_FF7F);
    wait_idle();
    rd(2'd3, v); chk("R12 kept after good transfer", v, 32'h1);
    wr(2'd3, 32'h0);
    rd(2'd3, v); chk("R12 kept after writing 0", v, 32'h1);
    wr(2'd3, 32'h1);
    rd(2'd3, v); chk("R12 cleared by writing 1", v, 32'h0);

    // R7 midpoint sampling: Th=11, mid=5
    wr(2'd1, 32'h0000_0106);
    acks(2, 0, 3);
    wr(2'd0, 32'h01C3_0F41);
    wait_idle();
    rd(2'd3, v); chk("R7 midpoint nack in last slot", v, 32'h1);
    wr(2'd3, 32'h1);
    acks(2, 2, 2);
    wr(2'd0, 32'h0155_AA2B);
    wait_idle();
    rd(2'd3, v); chk("R7 midpoint ack only", v, 32'h0);

    // R11 mode bits stored, no effect
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, v); chk("R11 mode readback", v, 32'h0000_005F);
    acks(0, 0, 0);
    wr(2'd0, 32'h0181_7E00);
    wait_idle();
    rd(2'd3, v); chk("R11 transfer unaffected", v, 32'h0);

    // Minimum counts, nack on address byte
    wr(2'd1, 32'h0);
    acks(1, 0, 0);
    wr(2'd0, 32'h0112_3456);
    wait_idle();
    rd(2'd3, v); chk("R8 nack on address byte", v, 32'h1);

    repeat (4) @(posedge clk);
    #2;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule